// File: doc/BRIEF.md
# Transmitter Sequential Reset Controller

This block orders the reset of a serial transmitter's two sublayers: the physical-medium-attachment layer (PMA) and the physical-coding layer (PCS). Three request inputs select the sequence. A full request and a PMA request both run the PMA phase first and then move into the PCS phase. A PCS request runs only the PCS phase. Every sequence starts when its request is released, on the high-to-low transition, and not while the request is held high.

Each phase has two parts: a one-cycle wait state, then a timed state whose length in cycles is a parameter. The PCS phase leaves its wait state only when the user-ready qualifier is high. The controller therefore stalls there, holding the PCS layer in reset, until user logic reports that it is ready. A done flag drops as soon as a request is accepted. It rises again when the controller returns to idle at the end of the PCS timed state.

Top module: `txrst_seq`

## Requirements
- R1: While and directly after the synchronous reset `rst`, `pma_rst`, `pcs_rst` and `done` are all 0, and the controller is idle.
- R2: Holding `full_req` high has no effect. On its high-to-low transition the controller raises `pma_rst` for exactly PMA_CYCLES+1 consecutive cycles: one wait cycle plus the timed part. `pcs_rst` is high in every cycle in which `pma_rst` is high.
- R3: After the PMA phase, the controller moves into the PCS phase with no further request, so `pcs_rst` stays high after `pma_rst` falls. A high-to-low transition of `pma_req` starts the same two-phase sequence as `full_req`.
- R4: In the PCS wait state, `pcs_rst` stays high and `pma_rst` stays low for as long as `user_rdy` is low.
- R5: The PCS timed part starts on the first clock edge at which `user_rdy` is high in the PCS wait state. It lasts exactly PCS_CYCLES cycles. With `user_rdy` held high, a full sequence keeps `pcs_rst` high for PMA_CYCLES+PCS_CYCLES+2 cycles.
- R6: A high-to-low transition of `pcs_req` seen in idle with `user_rdy` high raises `pcs_rst` for exactly PCS_CYCLES+1 cycles, and `pma_rst` stays low throughout.
- R7: A high-to-low transition of `pcs_req` seen while `user_rdy` is low is ignored. No reset starts, including when `user_rdy` rises later.
- R8: `done` goes low in the first cycle after an accepted request. It goes to 1 in the first idle cycle after the PCS timed part ends and stays 1 until the next accepted request.
- R9: High-to-low transitions of `pma_req` or `pcs_req` that arrive while a sequence is running are ignored, and the sequence keeps its length.
- R10: A high-to-low transition of `full_req` during a running sequence restarts it from the PMA wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| full_req | input | 1 | Full reset request; acts on its falling transition |
| pma_req | input | 1 | PMA reset request; acts on its falling transition |
| pcs_req | input | 1 | PCS-only reset request; acts on its falling transition when user_rdy is high |
| user_rdy | input | 1 | User-ready qualifier that gates entry into the PCS timed part |
| pma_rst | output | 1 | Reset to the PMA layer |
| pcs_rst | output | 1 | Reset to the PCS layer |
| done | output | 1 | Sequence completed; low while a reset is in progress |

## Verification
The assertions assume that requests are synchronous to `clk`. They also assume that each request is high for at least one clock edge before it is released, because a pulse too short to be registered produces no transition. The stimulus drives every input on the falling clock edge and holds each request high across one full rising edge. It never releases `pma_req` and `pcs_req` together in idle. Requests injected during a running sequence are spaced so that only one transition falls in any one cycle.

// File: rtl/txrst_pkg.sv
package txrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_PMA = 3'd1,
        ST_PMA_TIME = 3'd2,
        ST_WAIT_PCS = 3'd3,
        ST_PCS_TIME = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic full;
        logic pma;
        logic pcs;
    } req_t;

    localparam int unsigned NUM_REQ = 3;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/txrst_fall_det.sv
module txrst_fall_det #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[i];
        end
        assign fall[i] = prev_q & ~lvl[i];
    end
endmodule

// File: rtl/txrst_timer.sv
module txrst_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5: a running count steps down by exactly one per cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: a load takes effect on the next cycle
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/txrst_seq.sv
module txrst_seq
    import txrst_pkg::*;
#(
    parameter int unsigned PMA_CYCLES = 16,
    parameter int unsigned PCS_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic full_req,
    input  logic pma_req,
    input  logic pcs_req,
    input  logic user_rdy,
    output logic pma_rst,
    output logic pcs_rst,
    output logic done
);
    localparam int unsigned MAXC = max_u(PMA_CYCLES, PCS_CYCLES);
    localparam int unsigned CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] PMA_LOAD = CW'(PMA_CYCLES - 1);
    localparam logic [CW-1:0] PCS_LOAD = CW'(PCS_CYCLES - 1);

    seq_state_t    state_q, state_d;
    req_t          lvl, fall;
    logic [NUM_REQ-1:0] fall_vec;
    logic          t_load, t_zero, accept, done_q;
    logic [CW-1:0] t_val;

    assign lvl = '{full: full_req, pma: pma_req, pcs: pcs_req};

    txrst_fall_det #(.N(NUM_REQ)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .fall (fall_vec)
    );
    assign fall = req_t'(fall_vec);

    always_comb begin
        state_d = state_q;
        if (fall.full) begin
            state_d = ST_WAIT_PMA;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fall.pma)                   state_d = ST_WAIT_PMA;
                    else if (fall.pcs && user_rdy)  state_d = ST_WAIT_PCS;
                end
                ST_WAIT_PMA: state_d = ST_PMA_TIME;
                ST_PMA_TIME: if (t_zero)   state_d = ST_WAIT_PCS;
                ST_WAIT_PCS: if (user_rdy) state_d = ST_PCS_TIME;
                ST_PCS_TIME: if (t_zero)   state_d = ST_IDLE;
                default:                   state_d = ST_IDLE;
            endcase
        end
    end

    assign t_load = ((state_d == ST_PMA_TIME) && (state_q != ST_PMA_TIME)) ||
                    ((state_d == ST_PCS_TIME) && (state_q != ST_PCS_TIME));
    assign t_val  = (state_d == ST_PMA_TIME) ? PMA_LOAD : PCS_LOAD;

    txrst_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign accept = fall.full || ((state_q == ST_IDLE) && (state_d != ST_IDLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)
                done_q <= 1'b0;
            else if ((state_q == ST_PCS_TIME) && (state_d == ST_IDLE))
                done_q <= 1'b1;
        end
    end

    assign pma_rst = (state_q == ST_WAIT_PMA) || (state_q == ST_PMA_TIME);
    assign pcs_rst = (state_q != ST_IDLE);
    assign done    = done_q;

    // R2: the PCS layer is held in reset throughout the PMA phase
    p_pcs_covers_pma_r2: assert property (@(posedge clk) disable iff (rst)
        pma_rst |-> pcs_rst);

    // R3: when the PMA phase ends, the PCS phase follows with no new request
    p_pcs_handoff_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pma_rst) |-> (pcs_rst && !done));

    // R4: stall in the PCS wait state while user-ready is low
    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_PCS && !user_rdy && !fall.full) |=> (state_q == ST_WAIT_PCS));

    // R7: a PCS-only request is dropped when user-ready is low
    p_pcs_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && fall.pcs && !user_rdy && !fall.full && !fall.pma)
        |=> (state_q == ST_IDLE));

    // R8: done rises only as the PCS timed part completes
    p_done_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state_q == ST_PCS_TIME));

    // R8: done is never high while any layer is in reset
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !pcs_rst);

    // R10: a full request always restarts from the PMA wait state
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        fall.full |=> (state_q == ST_WAIT_PMA && !done));
endmodule

// File: tb/test_txrst_seq.sv
module test_txrst_seq;
    localparam int P = 16;
    localparam int C = 8;
    localparam int MAXS = 400;

    logic clk = 1'b0;
    logic rst, full_req, pma_req, pcs_req, user_rdy;
    logic pma_rst, pcs_rst, done;

    int total = 0;
    int bad = 0;

    int m_pma, m_pcs, m_done_idx, m_order_bad, m_done0;

    always #5 clk = ~clk;

    txrst_seq #(.PMA_CYCLES(P), .PCS_CYCLES(C)) i_txrst_seq (
        .clk(clk), .rst(rst), .full_req(full_req), .pma_req(pma_req),
        .pcs_req(pcs_req), .user_rdy(user_rdy),
        .pma_rst(pma_rst), .pcs_rst(pcs_rst), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // sel: 1 full, 2 pma, 3 pcs
    task automatic set_req(input int sel, input logic v);
        case (sel)
            1: full_req = v;
            2: pma_req  = v;
            3: pcs_req  = v;
            default: ;
        endcase
    endtask

    task automatic pulse(input int sel);
        @(negedge clk); set_req(sel, 1'b1);
        @(negedge clk); set_req(sel, 1'b0);
    endtask

    // sample each cycle after the edge that registers the release
    task automatic measure(input int raise_at, input int inj_idx, input int inj_sel);
        int seen_pcs_only = 0;
        m_pma = 0; m_pcs = 0; m_done_idx = -1; m_order_bad = 0; m_done0 = -1;
        for (int i = 0; i < MAXS; i++) begin
            @(posedge clk); #1;
            if (i == 0) m_done0 = int'(done);
            if (done) begin m_done_idx = i; break; end
            if (pma_rst) m_pma++;
            if (pcs_rst) m_pcs++;
            if (pma_rst && !pcs_rst) m_order_bad = 1;
            if (pma_rst && seen_pcs_only != 0) m_order_bad = 1;
            if (pcs_rst && !pma_rst) seen_pcs_only = 1;
            if (i == raise_at) user_rdy = 1'b1;
            if (i == inj_idx) set_req(inj_sel, 1'b1);
            if (i == inj_idx + 1) set_req(inj_sel, 1'b0);
        end
    endtask

    task automatic quiet_cycles(input int n, input string tag);
        int busy = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (pma_rst || pcs_rst || !done) busy++;
        end
        chk(busy == 0, tag, busy, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; full_req = 0; pma_req = 0; pcs_req = 0; user_rdy = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(!pma_rst && !pcs_rst && !done, "R1 outputs during reset",
            int'({pma_rst, pcs_rst, done}), 0);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(!pma_rst && !pcs_rst && !done, "R1 outputs after reset",
            int'({pma_rst, pcs_rst, done}), 0);
    endtask

    task automatic t_full();
        measure_after(1, 0, -10, 0);
        chk(m_pma == P + 1, "R2 full pma_rst length", m_pma, P + 1);
        chk(m_pcs == P + C + 2, "R5 full pcs_rst length", m_pcs, P + C + 2);
        chk(m_order_bad == 0, "R3 phase order", m_order_bad, 0);
        chk(m_done_idx == P + C + 2, "R8 done rise cycle", m_done_idx, P + C + 2);
    endtask

    task automatic measure_after(input int sel, input int raise_at, input int inj_idx, input int inj_sel);
        pulse(sel);
        measure(raise_at, inj_idx, inj_sel);
    endtask

    task automatic t_hold_high();
        int seen = 0;
        @(negedge clk); full_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            if (pma_rst || pcs_rst || !done) seen++;
        end
        chk(seen == 0, "R2 held full request has no effect", seen, 0);
        @(negedge clk); full_req = 1'b0;
        measure(0, -10, 0);
        chk(m_done0 == 0, "R8 done drops after accept", m_done0, 0);
        chk(m_pma == P + 1, "R2 pma length after long hold", m_pma, P + 1);
    endtask

    task automatic t_pma_only();
        measure_after(2, 0, -10, 0);
        chk(m_pma == P + 1, "R3 pma request pma length", m_pma, P + 1);
        chk(m_pcs == P + C + 2, "R3 pma request chains pcs", m_pcs, P + C + 2);
        chk(m_order_bad == 0, "R3 pma request order", m_order_bad, 0);
    endtask

    task automatic t_stall();
        int raise = 30;
        @(negedge clk); user_rdy = 1'b0;
        measure_after(1, raise, 20, 3);
        chk(m_pma == P + 1, "R4 pma length with stall", m_pma, P + 1);
        chk(m_pcs == raise + 1 + C, "R4 pcs held through stall", m_pcs, raise + 1 + C);
        chk(m_done_idx == raise + 1 + C, "R5 done after stall", m_done_idx, raise + 1 + C);
        chk(m_order_bad == 0, "R9 pcs edge in stall ignored", m_order_bad, 0);
    endtask

    task automatic t_pcs_only();
        measure_after(3, 0, -10, 0);
        chk(m_pma == 0, "R6 pcs only never touches pma", m_pma, 0);
        chk(m_pcs == C + 1, "R6 pcs only length", m_pcs, C + 1);
        chk(m_done0 == 0, "R8 done drops on pcs accept", m_done0, 0);
        chk(m_done_idx == C + 1, "R6 pcs only done cycle", m_done_idx, C + 1);
    endtask

    task automatic t_pcs_gated();
        @(negedge clk); user_rdy = 1'b0;
        pulse(3);
        quiet_cycles(4, "R7 pcs request with user_rdy low");
        @(negedge clk); user_rdy = 1'b1;
        quiet_cycles(6, "R7 no late start on user_rdy rise");
    endtask

    task automatic t_mid_ignore();
        measure_after(1, 0, 5, 2);
        chk(m_pma == P + 1, "R9 pma edge mid sequence ignored", m_pma, P + 1);
        chk(m_done_idx == P + C + 2, "R9 sequence length unchanged", m_done_idx, P + C + 2);
        measure_after(2, 0, P + 3, 3);
        chk(m_done_idx == P + C + 2, "R9 pcs edge in pcs phase ignored", m_done_idx, P + C + 2);
    endtask

    task automatic t_full_restart();
        measure_after(1, 0, 5, 1);
        chk(m_pma == 7 + P + 1, "R10 restart extends pma", m_pma, 7 + P + 1);
        chk(m_done_idx == 7 + P + C + 2, "R10 restart total length", m_done_idx, 7 + P + C + 2);
        measure_after(3, 0, 3, 1);
        chk(m_pma == P + 1, "R10 full restart from pcs only", m_pma, P + 1);
        chk(m_done_idx == 5 + P + C + 2, "R10 restart length from pcs", m_done_idx, 5 + P + C + 2);
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_full();
        t_hold_high();
        t_pma_only();
        t_stall();
        t_pcs_only();
        t_pcs_gated();
        t_mid_ignore();
        t_full_restart();
        report();
        $finish;
    end
endmodule